// File: doc/BRIEF.md
# Three-Way Compare Branch Target Unit

This execute-stage unit resolves one compare-and-branch operation that can go to one of three destinations. It subtracts two 64-bit register operands and reads the sign, overflow and zero flags of that difference as a signed comparison. The result selects a "less", an "equal" or a "greater" destination. All three destinations are encoded in a single 33-bit immediate, relative to the 48-bit program counter of the instruction. One cycle after a valid request, the unit reports whether the branch is taken and gives the 48-bit destination address.

The unit does not use three full-width adders. For each direction it adds the displacement to the low 16 bits of the PC only. The upper 32 PC bits are prepared in three forms: unchanged, incremented and decremented. After the direction is chosen, the carry or borrow out of the chosen low-half sum picks one of those three upper halves.

A mode input selects a two-way variant. In that variant the immediate carries only two wider displacements, and equal operands fall through with no branch taken.

Top module: `br3_target_unit`

## Requirements
- R1: The direction is a signed 64-bit comparison of `opa` against `opb`. It is "less" when `opa` < `opb`, "equal" when they are equal, and "greater" otherwise. The comparison is correct even when the subtraction overflows.
- R2: In three-way mode (`two_way`=0), `imm[10:0]` is the "less" displacement, `imm[21:11]` is the "equal" displacement and `imm[32:22]` is the "greater" displacement. The chosen field is sign-extended and multiplied by 2. The target is `pc` plus that value, modulo 2^48.
- R3: The target is exact for every `pc` value. This includes a low-half sum that crosses a 64 KiB boundary upward or downward, and wrap-around at 0 and at 2^48-1.
- R4: In three-way mode, every valid request gives `taken`=1.
- R5: In two-way mode (`two_way`=1), "less" uses `imm[15:0]` and "greater" uses `imm[31:16]`, each sign-extended and multiplied by 2 and added to `pc`. `imm[32]` has no effect on the result.
- R6: In two-way mode, equal operands give `taken`=0 at the result cycle.
- R7: The result appears one cycle after `in_valid`: `out_valid` is high in exactly the cycle after each valid request, and `taken` is 0 whenever `out_valid` is 0.
- R8: After reset, `out_valid`, `taken` and `target` are all 0.
- R9: While `in_valid` is low, `target` keeps its last value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Request strobe for the operands on this cycle |
| two_way | input | 1 | 1 selects the two-way variant, 0 the three-way variant |
| pc | input | 48 | Program counter of the branch |
| opa | input | 64 | First comparison operand |
| opb | input | 64 | Second comparison operand |
| imm | input | 33 | Packed displacement immediate |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| taken | output | 1 | Branch taken |
| target | output | 48 | Selected destination address |

## Verification
A wrong carry-to-upper-half decode or a swapped field shows on the `target` of the very result that needs it. It is visible on the cycle after that request and on no other. The stimulus therefore places `pc` right at 64 KiB edges and at both ends of the address range, with displacements of both signs. A compare flag that mishandles overflow chooses a wrong field only for operands of opposite sign near the range limits, so those pairs are driven on purpose. A flaw in the valid or enable path shows as a result that is missing, extra or changed while the unit is idle.

// File: rtl/br3_pkg.sv
package br3_pkg;
  localparam int unsigned PC_W   = 48;
  localparam int unsigned OP_W   = 64;
  localparam int unsigned IMM_W  = 33;
  localparam int unsigned LOW_W  = 16;
  localparam int unsigned F3_W   = 11;
  localparam int unsigned F2_W   = 16;
  localparam int unsigned N_DIR  = 3;

  typedef enum logic [1:0] {
    DIR_LT = 2'd0,
    DIR_EQ = 2'd1,
    DIR_GT = 2'd2
  } dir_e;
endpackage

// File: rtl/br3_flags.sv
module br3_flags #(
  parameter int unsigned OP_W = 64
) (
  input  logic [OP_W-1:0] opa,
  input  logic [OP_W-1:0] opb,
  output logic            lt,
  output logic            eq,
  output logic            gt
);
  logic [OP_W-1:0] diff;
  logic            sgn_f;
  logic            ovf_f;
  logic            zro_f;
  logic            neg_true;

  always_comb begin
    diff     = opa - opb;
    sgn_f    = diff[OP_W-1];
    ovf_f    = (opa[OP_W-1] ^ opb[OP_W-1]) & (diff[OP_W-1] ^ opa[OP_W-1]);
    zro_f    = ~|diff;
    neg_true = sgn_f ^ ovf_f;
    lt       = neg_true & ~zro_f;
    eq       = zro_f;
    gt       = ~neg_true & ~zro_f;
  end
endmodule

// File: rtl/br3_lowadd.sv
module br3_lowadd #(
  parameter int unsigned LOW_W = 16,
  parameter int unsigned IMM_W = 33,
  parameter int unsigned F3_W  = 11,
  parameter int unsigned F2_W  = 16,
  parameter int unsigned N_DIR = 3
) (
  input  logic [LOW_W-1:0]            pc_lo,
  input  logic [IMM_W-1:0]            imm,
  input  logic                        two_way,
  output logic [N_DIR-1:0][LOW_W-1:0] lo_sum,
  output logic [N_DIR-1:0][1:0]       adj
);
  localparam int unsigned SUM_W = LOW_W + 2;

  for (genvar k = 0; k < N_DIR; k++) begin : g_dir
    logic [F3_W-1:0]  fld3;
    logic [F2_W-1:0]  fld2;
    logic [SUM_W-1:0] off3;
    logic [SUM_W-1:0] off2;
    logic [SUM_W-1:0] off;
    logic [SUM_W-1:0] sum;

    assign fld3 = imm[k*F3_W +: F3_W];

    if (k == 0) begin : g_lo
      assign fld2 = imm[F2_W-1:0];
    end else if (k == N_DIR-1) begin : g_hi
      assign fld2 = imm[2*F2_W-1:F2_W];
    end else begin : g_mid
      assign fld2 = '0;
    end

    always_comb begin
      off3 = {{(SUM_W-F3_W-1){fld3[F3_W-1]}}, fld3, 1'b0};
      off2 = {{(SUM_W-F2_W-1){fld2[F2_W-1]}}, fld2, 1'b0};
      off  = two_way ? off2 : off3;
      sum  = {2'b00, pc_lo} + off;
    end

    assign lo_sum[k] = sum[LOW_W-1:0];
    assign adj[k]    = sum[SUM_W-1:LOW_W];
  end
endmodule

// File: rtl/br3_upsel.sv
module br3_upsel #(
  parameter int unsigned UP_W = 32
) (
  input  logic [UP_W-1:0] pc_hi,
  input  logic [1:0]      adj,
  output logic [UP_W-1:0] hi
);
  logic [UP_W-1:0] hi_inc;
  logic [UP_W-1:0] hi_dec;

  always_comb begin
    hi_inc = pc_hi + UP_W'(1);
    hi_dec = pc_hi - UP_W'(1);
    unique case (adj)
      2'b01:   hi = hi_inc;
      2'b11:   hi = hi_dec;
      default: hi = pc_hi;
    endcase
  end
endmodule

// File: rtl/br3_target_unit.sv
module br3_target_unit
  import br3_pkg::*;
#(
  parameter int unsigned P_PC_W  = PC_W,
  parameter int unsigned P_OP_W  = OP_W,
  parameter int unsigned P_IMM_W = IMM_W,
  parameter int unsigned P_LOW_W = LOW_W,
  parameter int unsigned P_F3_W  = F3_W,
  parameter int unsigned P_F2_W  = F2_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               two_way,
  input  logic [P_PC_W-1:0]  pc,
  input  logic [P_OP_W-1:0]  opa,
  input  logic [P_OP_W-1:0]  opb,
  input  logic [P_IMM_W-1:0] imm,
  output logic               out_valid,
  output logic               taken,
  output logic [P_PC_W-1:0]  target
);
  localparam int unsigned UP_W = P_PC_W - P_LOW_W;

  logic                          f_lt;
  logic                          f_eq;
  logic                          f_gt;
  dir_e                          dir;
  logic [N_DIR-1:0][P_LOW_W-1:0] lo_sum;
  logic [N_DIR-1:0][1:0]         adj;
  logic [P_LOW_W-1:0]            lo_pick;
  logic [1:0]                    adj_pick;
  logic [UP_W-1:0]               hi_pick;

  logic                          valid_d;
  logic                          taken_d;
  logic [P_PC_W-1:0]             target_d;
  logic                          target_en;
  logic                          valid_q;
  logic                          taken_q;
  logic [P_PC_W-1:0]             target_q;

  br3_flags #(.OP_W(P_OP_W)) u_flags (
    .opa (opa),
    .opb (opb),
    .lt  (f_lt),
    .eq  (f_eq),
    .gt  (f_gt)
  );

  br3_lowadd #(
    .LOW_W (P_LOW_W),
    .IMM_W (P_IMM_W),
    .F3_W  (P_F3_W),
    .F2_W  (P_F2_W),
    .N_DIR (N_DIR)
  ) u_lowadd (
    .pc_lo   (pc[P_LOW_W-1:0]),
    .imm     (imm),
    .two_way (two_way),
    .lo_sum  (lo_sum),
    .adj     (adj)
  );

  always_comb begin
    if (f_lt)      dir = DIR_LT;
    else if (f_gt) dir = DIR_GT;
    else           dir = DIR_EQ;
  end

  always_comb begin
    unique case (dir)
      DIR_LT: begin
        lo_pick  = lo_sum[0];
        adj_pick = adj[0];
      end
      DIR_GT: begin
        lo_pick  = lo_sum[2];
        adj_pick = adj[2];
      end
      default: begin
        lo_pick  = lo_sum[1];
        adj_pick = adj[1];
      end
    endcase
  end

  br3_upsel #(.UP_W(UP_W)) u_upsel (
    .pc_hi (pc[P_PC_W-1:P_LOW_W]),
    .adj   (adj_pick),
    .hi    (hi_pick)
  );

  // next-state
  always_comb begin
    valid_d   = in_valid;
    taken_d   = in_valid & (~two_way | ~f_eq);
    target_d  = {hi_pick, lo_pick};
    target_en = in_valid;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      taken_q  <= 1'b0;
      target_q <= '0;
    end else begin
      valid_q <= valid_d;
      taken_q <= taken_d;
      if (target_en) target_q <= target_d;
    end
  end

  assign out_valid = valid_q;
  assign taken     = taken_q;
  assign target    = target_q;
endmodule

// File: rtl/br3_chk.sv
module br3_chk #(
  parameter int unsigned C_PC_W  = 48,
  parameter int unsigned C_OP_W  = 64,
  parameter int unsigned C_IMM_W = 33,
  parameter int unsigned C_F3_W  = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               two_way,
  input logic [C_PC_W-1:0]  pc,
  input logic [C_OP_W-1:0]  opa,
  input logic [C_OP_W-1:0]  opb,
  input logic [C_IMM_W-1:0] imm,
  input logic               out_valid,
  input logic               taken,
  input logic [C_PC_W-1:0]  target
);
  logic [C_F3_W-1:0] eq_fld;
  logic [C_PC_W-1:0] eq_exp;
  logic              op_same;

  always_comb begin
    eq_fld  = imm[2*C_F3_W-1:C_F3_W];
    eq_exp  = pc + {{(C_PC_W-C_F3_W-1){eq_fld[C_F3_W-1]}}, eq_fld, 1'b0};
    op_same = (opa == opb);
  end

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R7
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R7
  AST_TAKEN_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> out_valid);  // R7
  AST_THREE_WAY_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !two_way) |=> taken);  // R4
  AST_TWO_WAY_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && two_way && op_same) |=> !taken);  // R6
  AST_EQ_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !two_way && op_same) |=> (target == $past(eq_exp)));  // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(target));  // R9
endmodule

bind br3_target_unit br3_chk #(
  .C_PC_W  (P_PC_W),
  .C_OP_W  (P_OP_W),
  .C_IMM_W (P_IMM_W),
  .C_F3_W  (P_F3_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .two_way   (two_way),
  .pc        (pc),
  .opa       (opa),
  .opb       (opb),
  .imm       (imm),
  .out_valid (out_valid),
  .taken     (taken),
  .target    (target)
);

// File: tb/br3_target_unit_tb_top.sv
`timescale 1ns/1ps
module br3_target_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        two_way;
  logic [47:0] pc;
  logic [63:0] opa;
  logic [63:0] opb;
  logic [32:0] imm;
  logic        out_valid;
  logic        taken;
  logic [47:0] target;

  int unsigned n_checks = 0;
  int unsigned n_fails  = 0;
  int unsigned cycles   = 0;
  bit          done     = 0;

  logic        q_taken[$];
  logic [47:0] q_tgt[$];
  logic        q_chk[$];
  string       q_tag[$];
  logic [47:0] last_tgt;

  br3_target_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .two_way   (two_way),
    .pc        (pc),
    .opa       (opa),
    .opb       (opb),
    .imm       (imm),
    .out_valid (out_valid),
    .taken     (taken),
    .target    (target)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  // reference model
  task automatic send(input logic [47:0] p, input logic [63:0] a, input logic [63:0] b,
                      input logic [32:0] im, input logic tw, input string tag);
    logic        lt;
    logic        eq;
    logic [47:0] d;
    logic        tk;
    logic        ck;
    lt = $signed(a) < $signed(b);
    eq = (a == b);
    tk = 1'b1;
    ck = 1'b1;
    if (!tw) begin
      logic [10:0] f;
      f = lt ? im[10:0] : (eq ? im[21:11] : im[32:22]);
      d = {{37{f[10]}}, f} << 1;
    end else begin
      logic [15:0] g;
      g = lt ? im[15:0] : im[31:16];
      d = {{32{g[15]}}, g} << 1;
      if (eq) begin
        tk = 1'b0;
        ck = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b1;
    two_way  = tw;
    pc       = p;
    opa      = a;
    opb      = b;
    imm      = im;
    q_taken.push_back(tk);
    q_tgt.push_back(p + d);
    q_chk.push_back(ck);
    q_tag.push_back(tag);
    last_tgt = p + d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (q_tag.size() == 0) begin
          check("R7 unexpected result", 64'(out_valid), 64'd0);
        end else begin
          logic        et;
          logic [47:0] eg;
          logic        ec;
          string       tg;
          et = q_taken.pop_front();
          eg = q_tgt.pop_front();
          ec = q_chk.pop_front();
          tg = q_tag.pop_front();
          check({tg, " taken"}, 64'(taken), 64'(et));
          if (ec) check({tg, " target"}, 64'(target), 64'(eg));
        end
      end else begin
        if (taken) check("R7 taken without out_valid", 64'(taken), 64'd0);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    two_way  = 1'b0;
    pc       = '0;
    opa      = '0;
    opb      = '0;
    imm      = '0;
    repeat (3) @(negedge clk);
    check("R8 reset out_valid", 64'(out_valid), 64'd0);
    check("R8 reset taken", 64'(taken), 64'd0);
    check("R8 reset target", 64'(target), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R1/R2: three fields, each direction
    send(48'h1234_5678_9000, 64'd5, 64'd9, {11'h010, 11'h020, 11'h030}, 1'b0, "R2 less");
    send(48'h1234_5678_9000, 64'd9, 64'd9, {11'h010, 11'h020, 11'h030}, 1'b0, "R2 equal");
    send(48'h1234_5678_9000, 64'd9, 64'd5, {11'h010, 11'h020, 11'h030}, 1'b0, "R2 greater");
    send(48'h0000_0000_4000, 64'd1, 64'd2, {11'h7FF, 11'h400, 11'h401}, 1'b0, "R2 negative less field");
    // R1: overflow in subtraction
    send(48'h0000_0001_0000, 64'h8000_0000_0000_0000, 64'd1, {11'h001, 11'h002, 11'h003}, 1'b0, "R1 min minus one is less");
    send(48'h0000_0001_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, {11'h001, 11'h002, 11'h003}, 1'b0, "R1 max vs -1 is greater");
    send(48'h0000_0001_0000, 64'hFFFF_FFFF_FFFF_FFFE, 64'd3, {11'h001, 11'h002, 11'h003}, 1'b0, "R1 negative vs positive less");
    // R3: 64 KiB crossings and wrap
    send(48'h0000_1234_FFFE, 64'd0, 64'd0, {11'h000, 11'h3FF, 11'h000}, 1'b0, "R3 cross up");
    send(48'h0000_1234_0002, 64'd0, 64'd0, {11'h000, 11'h400, 11'h000}, 1'b0, "R3 cross down");
    send(48'h0000_0000_0000, 64'd0, 64'd0, {11'h000, 11'h7FF, 11'h000}, 1'b0, "R3 wrap below zero");
    send(48'hFFFF_FFFF_FFFE, 64'd0, 64'd0, {11'h000, 11'h001, 11'h000}, 1'b0, "R3 wrap above max");
    send(48'h0000_5555_8000, 64'd1, 64'd0, {11'h3FF, 11'h000, 11'h000}, 1'b0, "R3 greater no cross");
    // R5/R6: two-way
    send(48'h0000_2222_0100, 64'd3, 64'd4, {1'b1, 16'h0040, 16'hFF00}, 1'b1, "R5 two-way less");
    send(48'h0000_2222_0100, 64'd4, 64'd3, {1'b1, 16'h0040, 16'hFF00}, 1'b1, "R5 two-way greater");
    send(48'h0000_2222_0100, 64'd4, 64'd4, {1'b1, 16'h0040, 16'hFF00}, 1'b1, "R6 two-way equal");
    send(48'h0000_2222_FFF0, 64'd9, 64'd1, {1'b0, 16'h7FFF, 16'h0000}, 1'b1, "R5 two-way big forward cross");
    send(48'h0000_2222_0010, 64'd1, 64'd9, {1'b1, 16'h0000, 16'h8000}, 1'b1, "R5 two-way big backward cross");
    send(48'h0000_0000_0000, 64'd1, 64'd9, {1'b0, 16'h0000, 16'hFFFF}, 1'b1, "R3 two-way wrap");
    idle(1);

    // R9: idle inputs have no effect on target
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      pc  = {$urandom, $urandom};
      imm = {$urandom, $urandom};
      opa = {$urandom, $urandom};
      two_way = i[0];
      check("R9 target held while idle", 64'(target), 64'(last_tgt));
      check("R9 idle out_valid", 64'(out_valid), 64'd0);
    end

    // random mix: R1 R2 R4 R5 R6
    for (int i = 0; i < 200; i++) begin
      logic [63:0] a;
      logic [63:0] b;
      a = {$urandom, $urandom};
      b = ($urandom % 4 == 0) ? a : {$urandom, $urandom};
      if ($urandom % 3 == 0) b = a ^ 64'h8000_0000_0000_0000;
      send({$urandom, $urandom}, a, b, {$urandom, $urandom}, 1'($urandom), "R4 random mix");
      if ($urandom % 5 == 0) idle(1);
    end
    idle(3);
    check("R7 all results delivered", 64'(q_tag.size()), 64'd0);
    done = 1;
    finish_run();
  end
endmodule